// File: doc/BRIEF.md
# Page Programming Sequencer for a Paged Nonvolatile Memory

This block is the host-side controller that programs a range of pages into an asynchronous, page-organised nonvolatile memory. A page holds 128 bytes. The byte index fills the low 7 address bits and the page number fills the bits above them. The memory latches one page of bytes from a burst of write strobes. It starts its internal erase/write cycle by itself once the burst has stopped for a while. While that cycle runs, a read returns the bitwise complement of the last byte written.

After a `start` the sequencer holds the write-protect line (`mem_inh_n`) low until the supplies report ready. It then releases that line and programs the pages in ascending order from `first_page` to `last_page`. The bytes come from a source that is indexed by the same address the memory sees. After each page it waits for the memory in one of two ways. In fixed-wait mode it idles for a long timer. In polling mode it waits a shorter hold-off and then reads the last address back until the true byte returns. A poll limit turns an endless wait into a timeout abort. Once the whole range is written, it reads the range back and compares every byte with the source. It then drops the write-protect line and pulses `done`. At that point it reports a timeout flag, a verify-mismatch flag and the first failing address.

The states are as follows:
- IDLE, PWR (wait for supplies) and ARM (protect released).
- WSET, WSTB and WHLD: the write phases for each byte.
- HOLD (poll hold-off), PRD and PGAP: the poll read and the gap between polls.
- FIXED (fixed wait) and NEXTPG (page step).
- VRD and VGAP: the verify read and the gap between verify reads.
- END.

The transitions are:
- IDLE→PWR on start.
- PWR→ARM on supply ready.
- ARM→WSET.
- WSET→WSTB→WHLD, each phase lasting `PULSE_CYC` cycles.
- WHLD→WSET for the next byte.
- WHLD→HOLD or FIXED after byte 127.
- HOLD→PRD.
- PRD→PGAP→PRD while the read-back mismatches.
- PRD→NEXTPG on a match.
- PRD→END on timeout.
- FIXED→NEXTPG.
- NEXTPG→WSET for the next page, or NEXTPG→VRD after the last page.
- VRD→VGAP→VRD while the bytes match.
- VRD→END on a mismatch or after the final byte.
- END→IDLE.

Top module: `page_prog_seq`

## Requirements
- R1: Out of reset the block is idle: `mem_inh_n`=0, `mem_ce_n`=`mem_we_n`=`mem_oe_n`=1, `busy`=0, `done`=0.
- R2: `mem_inh_n` stays 0 after a start until `supply_ready` is 1. It is 1 before the first write strobe, and it is 0 again in the cycle `done` is high. No write strobe occurs while it is 0.
- R3: Each page is written as exactly 128 strobes. The memory address is {page, byte}, with the byte in bits 6:0 running 0 to 127.
- R4: Throughout every write strobe, `mem_ce_n`=0, `mem_we_n`=0 and `mem_oe_n`=1. The write-enable low time and the high time between strobes are each at least `PULSE_CYC` host cycles. The address and data are held stable while the strobe is low.
- R5: In polling mode (`use_poll`=1), the first read after a page's last strobe comes no earlier than `HOLDOFF`×`PGM_DIV` host cycles after that strobe ends. Each poll reads the last address written. The page is complete when the read-back equals the source byte, and complemented data counts as not complete.
- R6: In fixed mode (`use_poll`=0), no bus access occurs for `FIXED_WAIT`×`PGM_DIV` host cycles after a page's last strobe, and no poll reads are made.
- R7: Pages are written in ascending order from `first_page` to `last_page`. When the sequence ends, those pages of memory hold the source bytes and other pages are unchanged.
- R8: After the last page, every address of the range is read in ascending order and compared with the source. The first mismatch sets `verify_err`, stores its address in `fail_addr` and ends the sequence. A clean range leaves `verify_err`=0.
- R9: If `POLL_MAX` consecutive poll reads mismatch, the block sets `timeout_err`, drives `mem_inh_n` low and ends with `done`.
- R10: `done` is a single-cycle pulse. `busy` is 1 from an accepted start until `done`, then 0.
- R11: A `start` while `busy`=1 has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming session (sampled in IDLE) |
| first_page | input | PAGE_W | First page to program |
| last_page | input | PAGE_W | Last page to program |
| use_poll | input | 1 | 1 = poll for completion, 0 = fixed wait |
| supply_ready | input | 1 | Supplies are up |
| src_addr | output | PAGE_W+BYTE_W | Address of the requested source byte |
| src_data | input | DATA_W | Source byte for `src_addr` |
| mem_addr | output | PAGE_W+BYTE_W | Memory address bus |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_wdata_en | output | 1 | Host drives the data bus |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_inh_n | output | 1 | Write protect release, active low protect |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout_err | output | 1 | Poll limit reached (valid from `done`) |
| verify_err | output | 1 | Read-back mismatch (valid from `done`) |
| fail_addr | output | PAGE_W+BYTE_W | First mismatching address |

## Verification
The bus outputs decode the state register directly, so every strobe or read starts in the cycle after the edge that entered its state. The bench therefore samples on the falling clock edge and measures phase widths and gaps in whole host cycles from the end of a strobe to the next chip-enable fall. The long waits are counted from the cycle the wait state is entered, so the gap after a page's last strobe is `PULSE_CYC` plus the wait length, and the checks compare against a lower bound. The flags and `fail_addr` are registered on the edge that enters END, so they are sampled in the same falling-edge sample in which `done` is high. The memory contents and the counts of strobes and reads are judged only after `done` has been seen.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PWR,
        S_ARM,
        S_WSET,
        S_WSTB,
        S_WHLD,
        S_HOLD,
        S_PRD,
        S_PGAP,
        S_FIXED,
        S_NEXTPG,
        S_VRD,
        S_VGAP,
        S_END
    } pps_state_e;

endpackage

// File: rtl/pps_delay.sv
module pps_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         en,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (en && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/pps_tick.sv
module pps_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (clr || cnt == CW'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = !clr && (cnt == CW'(DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/pps_cursor.sv
module pps_cursor #(
    parameter int PAGE_W = 10,
    parameter int BYTE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_page,
    input  logic              step,
    input  logic              next_page,
    output logic [PAGE_W-1:0] page,
    output logic [BYTE_W-1:0] byte_idx,
    output logic              last_byte
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page     <= '0;
            byte_idx <= '0;
        end else if (load) begin
            page     <= load_page;
            byte_idx <= '0;
        end else if (next_page) begin
            page     <= page + 1'b1;
            byte_idx <= '0;
        end else if (step) begin
            byte_idx <= byte_idx + 1'b1;
            if (last_byte) begin
                page <= page + 1'b1;
            end
        end
    end

    assign last_byte = (byte_idx == {BYTE_W{1'b1}});

endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
    import pps_pkg::*;
#(
    parameter int PAGE_W     = 10,
    parameter int BYTE_W     = 7,
    parameter int DATA_W     = 8,
    parameter int PULSE_CYC  = 4,
    parameter int PGM_DIV    = 100,
    parameter int HOLDOFF    = 500,
    parameter int FIXED_WAIT = 20500,
    parameter int POLL_MAX   = 4096,
    localparam int ADDR_W    = PAGE_W + BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAGE_W-1:0] first_page,
    input  logic [PAGE_W-1:0] last_page,
    input  logic              use_poll,
    input  logic              supply_ready,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_inh_n,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic              verify_err,
    output logic [ADDR_W-1:0] fail_addr
);

    localparam int LONG_MAX = (FIXED_WAIT > HOLDOFF) ? FIXED_WAIT : HOLDOFF;
    localparam int LW_W     = $clog2(LONG_MAX + 1);
    localparam int PH_W     = $clog2(PULSE_CYC + 1);
    localparam int POLL_W   = $clog2(POLL_MAX + 1);

    pps_state_e st, nxt;

    logic [PAGE_W-1:0] first_q, last_q;
    logic              poll_q;
    logic [POLL_W-1:0] poll_cnt;

    logic              ph_ld, ph_zero;
    logic              lw_ld, lw_fixed, lw_zero, tick;
    logic [LW_W-1:0]   lw_val;
    logic              cur_ld, cur_step, cur_npg, cur_last;
    logic [PAGE_W-1:0] cur_page, cur_ld_page;
    logic [BYTE_W-1:0] cur_byte;
    logic              accept, poll_clr, poll_inc, set_to, set_vf, rd_ok;

    // ---------------- sub-blocks ----------------
    pps_delay #(.W(PH_W)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ph_ld),
        .val  (PH_W'(PULSE_CYC - 1)),
        .en   (1'b1),
        .zero (ph_zero)
    );

    pps_tick #(.DIV(PGM_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (lw_ld),
        .tick (tick)
    );

    assign lw_val = lw_fixed ? LW_W'(FIXED_WAIT) : LW_W'(HOLDOFF);

    pps_delay #(.W(LW_W)) u_long (
        .clk  (clk),
        .rst_n(rst_n),
        .load (lw_ld),
        .val  (lw_val),
        .en   (tick),
        .zero (lw_zero)
    );

    assign cur_ld_page = (st == S_IDLE) ? first_page : first_q;

    pps_cursor #(.PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cur_ld),
        .load_page(cur_ld_page),
        .step     (cur_step),
        .next_page(cur_npg),
        .page     (cur_page),
        .byte_idx (cur_byte),
        .last_byte(cur_last)
    );

    assign mem_addr  = {cur_page, cur_byte};
    assign src_addr  = mem_addr;
    assign mem_wdata = src_data;
    assign rd_ok     = (mem_rdata == src_data);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // ---------------- next state and control strobes ----------------
    always_comb begin
        nxt      = st;
        ph_ld    = 1'b0;
        lw_ld    = 1'b0;
        lw_fixed = 1'b0;
        cur_ld   = 1'b0;
        cur_step = 1'b0;
        cur_npg  = 1'b0;
        accept   = 1'b0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        set_to   = 1'b0;
        set_vf   = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (start) begin
                    nxt    = S_PWR;
                    accept = 1'b1;
                    cur_ld = 1'b1;
                end
            end
            S_PWR: begin
                if (supply_ready) nxt = S_ARM;
            end
            S_ARM: begin
                nxt   = S_WSET;
                ph_ld = 1'b1;
            end
            S_WSET: begin
                if (ph_zero) begin
                    nxt   = S_WSTB;
                    ph_ld = 1'b1;
                end
            end
            S_WSTB: begin
                if (ph_zero) begin
                    nxt   = S_WHLD;
                    ph_ld = 1'b1;
                end
            end
            S_WHLD: begin
                if (ph_zero) begin
                    if (cur_last) begin
                        lw_ld = 1'b1;
                        if (poll_q) begin
                            nxt      = S_HOLD;
                            poll_clr = 1'b1;
                        end else begin
                            nxt      = S_FIXED;
                            lw_fixed = 1'b1;
                        end
                    end else begin
                        nxt      = S_WSET;
                        cur_step = 1'b1;
                        ph_ld    = 1'b1;
                    end
                end
            end
            S_HOLD: begin
                if (lw_zero) begin
                    nxt   = S_PRD;
                    ph_ld = 1'b1;
                end
            end
            S_PRD: begin
                if (ph_zero) begin
                    if (rd_ok) begin
                        nxt = S_NEXTPG;
                    end else if (poll_cnt == POLL_W'(POLL_MAX - 1)) begin
                        nxt    = S_END;
                        set_to = 1'b1;
                    end else begin
                        nxt      = S_PGAP;
                        poll_inc = 1'b1;
                        ph_ld    = 1'b1;
                    end
                end
            end
            S_PGAP: begin
                if (ph_zero) begin
                    nxt   = S_PRD;
                    ph_ld = 1'b1;
                end
            end
            S_FIXED: begin
                if (lw_zero) nxt = S_NEXTPG;
            end
            S_NEXTPG: begin
                ph_ld = 1'b1;
                if (cur_page == last_q) begin
                    nxt    = S_VRD;
                    cur_ld = 1'b1;
                end else begin
                    nxt     = S_WSET;
                    cur_npg = 1'b1;
                end
            end
            S_VRD: begin
                if (ph_zero) begin
                    if (!rd_ok) begin
                        nxt    = S_END;
                        set_vf = 1'b1;
                    end else if (cur_page == last_q && cur_last) begin
                        nxt = S_END;
                    end else begin
                        nxt      = S_VGAP;
                        cur_step = 1'b1;
                        ph_ld    = 1'b1;
                    end
                end
            end
            S_VGAP: begin
                if (ph_zero) begin
                    nxt   = S_VRD;
                    ph_ld = 1'b1;
                end
            end
            S_END: begin
                nxt = S_IDLE;
            end
            default: begin
                nxt = S_IDLE;
            end
        endcase
    end

    // ---------------- bus and status outputs ----------------
    always_comb begin
        mem_ce_n     = 1'b1;
        mem_we_n     = 1'b1;
        mem_oe_n     = 1'b1;
        mem_inh_n    = 1'b1;
        mem_wdata_en = 1'b0;
        unique case (st)
            S_IDLE, S_PWR, S_END: mem_inh_n = 1'b0;
            S_WSET, S_WHLD:       mem_wdata_en = 1'b1;
            S_WSTB: begin
                mem_wdata_en = 1'b1;
                mem_ce_n     = 1'b0;
                mem_we_n     = 1'b0;
            end
            S_PRD, S_VRD: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            default: ;
        endcase
        busy = (st != S_IDLE);
        done = (st == S_END);
    end

    // ---------------- session registers and flags ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q     <= '0;
            last_q      <= '0;
            poll_q      <= 1'b0;
            poll_cnt    <= '0;
            timeout_err <= 1'b0;
            verify_err  <= 1'b0;
            fail_addr   <= '0;
        end else begin
            if (accept) begin
                first_q     <= first_page;
                last_q      <= last_page;
                poll_q      <= use_poll;
                timeout_err <= 1'b0;
                verify_err  <= 1'b0;
                fail_addr   <= '0;
            end
            if (poll_clr) begin
                poll_cnt <= '0;
            end else if (poll_inc) begin
                poll_cnt <= poll_cnt + 1'b1;
            end
            if (set_to) timeout_err <= 1'b1;
            if (set_vf) begin
                verify_err <= 1'b1;
                fail_addr  <= mem_addr;
            end
        end
    end

    // ---------------- assertions ----------------
    // R4
    we_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    // R4
    we_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    // R2
    no_write_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_inh_n |-> mem_we_n);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9
    timeout_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> !mem_inh_n);

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/tb_page_prog_seq.sv
`timescale 1ns/1ps
module tb_page_prog_seq;

    localparam int PW    = 3;
    localparam int BW    = 7;
    localparam int AW    = PW + BW;
    localparam int NB    = 1 << AW;
    localparam int PCYC  = 2;
    localparam int DIV   = 2;
    localparam int HOLD  = 10;
    localparam int FIX   = 35;
    localparam int PMAX  = 24;
    localparam int BLC   = 20;   // model: idle cycles after last byte before programming
    localparam int PROG  = 45;   // model: programming cycles

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] first_page = '0, last_page = '0;
    logic          use_poll = 1'b0, supply_ready = 1'b0;
    logic [AW-1:0] src_addr, mem_addr, fail_addr;
    logic [7:0]    src_data, mem_wdata, mem_rdata;
    logic          mem_wdata_en, mem_ce_n, mem_we_n, mem_oe_n, mem_inh_n;
    logic          busy, done, timeout_err, verify_err;

    always #2.5 clk = ~clk;

    page_prog_seq #(
        .PAGE_W(PW), .BYTE_W(BW), .DATA_W(8), .PULSE_CYC(PCYC), .PGM_DIV(DIV),
        .HOLDOFF(HOLD), .FIXED_WAIT(FIX), .POLL_MAX(PMAX)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .first_page(first_page),
        .last_page(last_page), .use_poll(use_poll), .supply_ready(supply_ready),
        .src_addr(src_addr), .src_data(src_data), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en), .mem_rdata(mem_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_inh_n(mem_inh_n), .busy(busy), .done(done), .timeout_err(timeout_err),
        .verify_err(verify_err), .fail_addr(fail_addr)
    );

    int checks = 0, failures = 0;
    logic [7:0] key = 8'h00;

    function automatic logic [7:0] src_fn(input logic [AW-1:0] a, input logic [7:0] k);
        logic [15:0] t;
        t = 16'(a) * 16'd29 + 16'(a >> 7) * 16'd53;
        return t[7:0] ^ k;
    endfunction

    assign src_data = src_fn(src_addr, key);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem [NB];
    logic [7:0] exp_mem [NB];
    logic [7:0] latch [128];
    int         mstate = 0, mcnt = 0;
    logic [PW-1:0] lpage = '0;
    logic [7:0] last_data = 8'h00, cap_data = 8'h00;
    logic [AW-1:0] cap_addr = '0, last_wa = '0;
    bit hang = 0, abort_prog = 0, flip_en = 0;
    logic [AW-1:0] flip_addr = '0;

    always_comb begin
        if (!mem_ce_n && !mem_oe_n) begin
            if (mstate != 0) mem_rdata = ~last_data;
            else mem_rdata = mem[mem_addr] ^ ((flip_en && mem_addr == flip_addr) ? 8'h10 : 8'h00);
        end else begin
            mem_rdata = 8'h00;
        end
    end

    // ---------------- monitor counters ----------------
    bit  prev_we = 1, prev_ce = 1;
    int  we_low = 0, since_wr = 1000, strobes = 0, total = 0;
    int  v_lvl = 0, v_width = 0, v_inh = 0, v_order = 0, v_busywr = 0, v_rdaddr = 0;
    int  busy_reads = 0, vfy_reads = 0, min_gap = 1000000, ce_falls = 0, done_width = 0;
    bit  pending = 0, done_seen = 0, d_to = 0, d_vf = 0, d_inh = 1;
    logic [AW-1:0] exp_wa = '0, d_fail = '0;

    always @(negedge clk) begin
        since_wr++;
        if (abort_prog) mstate = 0;
        // model state advance
        if (mstate == 1) begin
            mcnt++;
            if (mcnt >= BLC) begin mstate = 2; mcnt = 0; end
        end else if (mstate == 2 && !hang) begin
            mcnt++;
            if (mcnt >= PROG) begin
                for (int i = 0; i < 128; i++) mem[{lpage, 7'(i)}] = latch[i];
                mstate = 0;
            end
        end
        // chip-enable fall: any bus access
        if (prev_ce && !mem_ce_n) begin
            ce_falls++;
            if (pending) begin
                if (since_wr < min_gap) min_gap = since_wr;
                pending = 0;
            end
            if (!mem_oe_n) begin
                if (mstate != 0) begin
                    busy_reads++;
                    if (mem_addr != last_wa) v_rdaddr++;
                end else if (strobes == total) begin
                    vfy_reads++;
                end
            end
        end
        // write strobe start
        if (prev_we && !mem_we_n) begin
            if (mem_ce_n || !mem_oe_n) v_lvl++;
            if (!mem_inh_n || !supply_ready) v_inh++;
            if (since_wr < PCYC) v_width++;
            if (mem_addr != exp_wa) v_order++;
            if (mstate == 2) v_busywr++;
            if (mstate == 0) lpage = mem_addr[AW-1:BW];
            exp_wa = exp_wa + 1'b1;
            we_low = 0;
        end
        if (!mem_we_n) begin
            we_low++;
            cap_addr = mem_addr;
            cap_data = mem_wdata;
        end
        // write strobe end
        if (!prev_we && mem_we_n) begin
            if (we_low < PCYC) v_width++;
            latch[cap_addr[BW-1:0]] = cap_data;
            last_data = cap_data;
            last_wa = cap_addr;
            strobes++;
            since_wr = 0;
            if (mstate != 2) begin mstate = 1; mcnt = 0; end
            if (cap_addr[BW-1:0] == 7'h7f) pending = 1;
        end
        if (done) begin
            done_width++;
            if (!done_seen) begin
                d_to = timeout_err; d_vf = verify_err; d_fail = fail_addr; d_inh = mem_inh_n;
            end
            done_seen = 1;
        end
        prev_we = mem_we_n;
        prev_ce = mem_ce_n;
    end

    // ---------------- one programming session ----------------
    task automatic run(input int fp, input int lp, input bit poll, input int ready_delay,
                       input bit extra_start, input bit exp_to, input bit exp_vf,
                       input logic [AW-1:0] exp_fail, input string tag);
        int waited;
        int np;
        np = lp - fp + 1;
        @(negedge clk);
        key = 8'($urandom);
        v_lvl = 0; v_width = 0; v_inh = 0; v_order = 0; v_busywr = 0; v_rdaddr = 0;
        busy_reads = 0; vfy_reads = 0; min_gap = 1000000; ce_falls = 0; done_width = 0;
        strobes = 0; total = np * 128; done_seen = 0; pending = 0;
        exp_wa = AW'(fp * 128);
        first_page = PW'(fp); last_page = PW'(lp); use_poll = poll;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (ready_delay > 0) begin
            repeat (ready_delay) @(negedge clk);
            chk(mem_inh_n == 0 && busy == 1 && ce_falls == 0, "R2 protect held until supply ready",
                int'(mem_inh_n) * 10 + ce_falls, 0);
        end
        supply_ready = 1'b1;
        if (extra_start) begin
            repeat (300) @(negedge clk);
            first_page = '0; last_page = '1; use_poll = ~poll;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done_seen && waited < 40000) begin
            @(negedge clk);
            waited++;
        end
        repeat (3) @(negedge clk);
        chk(done_seen, {"R10 done reached ", tag}, int'(done_seen), 1);
        chk(done_width == 1 && busy == 0, {"R10 single done pulse then idle ", tag}, done_width, 1);
        chk(d_inh == 0, {"R2 protect low at done ", tag}, int'(d_inh), 0);
        chk(v_inh == 0, {"R2 no strobe while protected ", tag}, v_inh, 0);
        chk(v_lvl == 0, {"R4 strobe levels ", tag}, v_lvl, 0);
        chk(v_width == 0, {"R4 strobe widths ", tag}, v_width, 0);
        chk(v_order == 0, {"R3 R7 address order ", tag}, v_order, 0);
        chk(d_to == exp_to, {"R9 timeout flag ", tag}, int'(d_to), int'(exp_to));
        chk(d_vf == exp_vf, {"R8 verify flag ", tag}, int'(d_vf), int'(exp_vf));
        if (exp_to) begin
            chk(strobes == 128, "R3 strobes before timeout", strobes, 128);
            chk(busy_reads == PMAX, "R9 poll count before abort", busy_reads, PMAX);
            abort_prog = 1;
            @(negedge clk);
            abort_prog = 0;
        end else begin
            chk(strobes == total, {"R3 strobe count ", tag}, strobes, total);
            chk(v_busywr == 0, {"R5 R6 no write during programming ", tag}, v_busywr, 0);
            if (poll) begin
                chk(min_gap >= HOLD * DIV, {"R5 poll hold-off ", tag}, min_gap, HOLD * DIV);
                chk(v_rdaddr == 0 && busy_reads > 0, {"R5 polls hit last address ", tag},
                    v_rdaddr, 0);
            end else begin
                chk(min_gap >= FIX * DIV, {"R6 fixed wait gap ", tag}, min_gap, FIX * DIV);
                chk(busy_reads == 0, {"R6 no polling ", tag}, busy_reads, 0);
            end
            if (exp_vf) begin
                chk(d_fail == exp_fail, {"R8 failing address ", tag}, int'(d_fail), int'(exp_fail));
                chk(vfy_reads == int'(exp_fail) - fp * 128 + 1 + (poll ? 1 : 0),
                    {"R8 verify stops at mismatch ", tag}, vfy_reads,
                    int'(exp_fail) - fp * 128 + 1 + (poll ? 1 : 0));
            end else begin
                chk(vfy_reads == total + (poll ? 1 : 0), {"R8 full range read back ", tag},
                    vfy_reads, total + (poll ? 1 : 0));
            end
            for (int a = fp * 128; a < (lp + 1) * 128; a++) exp_mem[a] = src_fn(AW'(a), key);
        end
        begin
            int bad;
            int first_bad;
            bad = 0;
            first_bad = -1;
            for (int a = 0; a < NB; a++) begin
                if (mem[a] != exp_mem[a]) begin
                    bad++;
                    if (first_bad < 0) first_bad = a;
                end
            end
            chk(bad == 0, {"R7 memory image ", tag}, first_bad, -1);
        end
    endtask

    // ---------------- watchdog ----------------
    bit finished = 0;
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int unused;
        unused = int'($urandom(32'd4242));
        for (int a = 0; a < NB; a++) begin
            mem[a] = 8'hff;
            exp_mem[a] = 8'hff;
        end
        repeat (4) @(negedge clk);
        chk(mem_inh_n == 0 && mem_ce_n && mem_we_n && mem_oe_n && !busy && !done,
            "R1 reset state", int'({mem_inh_n, mem_ce_n, mem_we_n, mem_oe_n, busy, done}), 6'b011100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_inh_n == 0 && !busy, "R1 idle after reset", int'(busy), 0);

        // directed: two pages, polling, delayed supplies, stray start while busy (R11)
        run(1, 2, 1'b1, 40, 1'b1, 1'b0, 1'b0, '0, "R11 poll 1..2");
        // directed: single page, fixed wait, boundary top page
        run(7, 7, 1'b0, 0, 1'b0, 1'b0, 1'b0, '0, "fixed 7");
        // random ranges and modes
        for (int i = 0; i < 3; i++) begin
            int fp;
            int lp;
            fp = int'($urandom_range(0, 6));
            lp = fp + int'($urandom_range(0, 1));
            run(fp, lp, 1'($urandom_range(0, 1)), 0, 1'b0, 1'b0, 1'b0, '0, "random");
        end
        // verify mismatch on a read-corrupted byte (not the page's last byte)
        flip_addr = AW'(3 * 128 + int'($urandom_range(0, 126)));
        flip_en = 1;
        run(3, 3, 1'b1, 0, 1'b0, 1'b0, 1'b1, flip_addr, "mismatch");
        flip_en = 0;
        // poll timeout: programming never finishes
        hang = 1;
        run(0, 0, 1'b1, 0, 1'b0, 1'b1, 1'b0, '0, "timeout");
        hang = 0;
        // recovery after abort: page 0 in fixed mode
        run(0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, '0, "after abort");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule